// File: doc/BRIEF.md
# Truncated Unsigned Multiplier with Column Bypass

This block multiplies two unsigned operands of equal width and returns a product of the same width. It keeps only the upper half of the product. Partial products whose weight lies below the top dropped column are never formed. The top dropped column is not added at its own weight. Instead it is folded into a compensation term that raises the kept result by one unit for each set bit in that column. The block is purely combinational and suits low-power signal-processing datapaths that accept a small, input-dependent truncation error.

The kept partial products are summed in two carry-save arrays that run side by side. One takes the low half of the multiplier rows and the other takes the high half. A final merging adder joins the two. Adder cells are grouped by multiplicand bit. When that bit is zero, every cell in its group passes its incoming sum straight through, and the group's outgoing carries are forced low.

The compensation network scans each half of the top dropped column with a chain of AND/OR pairs. Each AND output enters the kept array as a carry into the cell group of the multiplicand bit it came from. The last OR output of each half goes into the merging adder.

Top module: `trunc_colbypass_mult`

## Requirements
- R1: For operands a and b of width W, `prod` equals ((S + c·2^W) / 2^W) mod 2^W, where S is the sum of a_i·b_j·2^(i+j) over i+j ≥ W, and c is the number of set terms a_i·b_j with i+j = W−1.
- R2: A partial product of weight below 2^(W−1) has no effect on `prod`. For example, a = 2^i and b = 2^j with i+j < W−1 give 0.
- R3: Each half of the dropped column (rows 0..W/2−1 and rows W/2..W−1) contributes exactly its own count of ones to the kept sum. A single set term at weight 2^(W−1) yields `prod` = 1.
- R4: A compensation carry enters only the cell group of a multiplicand bit that is 1. A group with a zero multiplicand bit never receives one.
- R5: When multiplicand bit i is 0, the cell group of bit i produces no carry out of either sub-array, and the arithmetic result is unchanged (R1 still holds).
- R6: If either operand is zero, `prod` is zero.
- R7: With both operands all ones, `prod` is 2^W − 1 for W = 8 and follows R1 for other widths.
- R8: The merging adder returns, modulo 2^W, the sum of both sub-arrays' sum and carry vectors plus the two final compensation bits.
- R9: The width W is a parameter. It must be even and at least 4, and 4, 8 and 16 are all valid. Each sub-array takes W/2 multiplier rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Multiplicand; zero bits bypass their cell groups |
| mplier | input | WIDTH | Multiplier; rows split between the two sub-arrays |
| prod | output | WIDTH | Truncated, compensated product |

## Verification
At width 8 every operand pair is applied, and the result is compared with an arithmetic model of the truncation and the bit count. This separates a correct array from one with a misrouted sum, carry or compensation bit anywhere in the structure. A width-4 copy is swept completely as well, and a width-16 copy receives random multipliers against multiplicands made sparse by ANDing several random words. The sparse multiplicands load most cell groups into bypass, so a fault in the bypass path shows up. Directed single-bit pairs at weights just below, at and above the top dropped column tell dropped terms apart from compensated terms. Zero and all-ones operands pin the two ends of the range.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   // first multiplier row of a sub-array holding a kept cell in a given multiplicand group
   function automatic int first_row(input int col, input int row_lo, input int width);
      return (width - col > row_lo) ? (width - col) : row_lo;
   endfunction

endpackage

// File: rtl/tcm_bypass_cell.sv
module tcm_bypass_cell (
   input  logic en,
   input  logic mb,
   input  logic sum_in,
   input  logic car_in,
   output logic sum_out,
   output logic car_out
);
   logic pp;
   logic fa_s;

   assign pp      = en & mb;
   assign fa_s    = pp ^ sum_in ^ car_in;
   assign car_out = (pp & sum_in) | (pp & car_in) | (sum_in & car_in);
   // a disabled group forwards the incoming sum untouched
   assign sum_out = en ? fa_s : sum_in;
endmodule

// File: rtl/tcm_bias_net.sv
module tcm_bias_net #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] cin_lo,
   output logic [WIDTH-1:0] cin_hi,
   output logic             tail_lo,
   output logic             tail_hi
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] col;

   for (genvar t = 0; t < WIDTH; t++) begin : g_col
      assign col[t] = a[WIDTH-1-t] & b[t];
   end

   always_comb begin
      logic acc;
      cin_lo = '0;
      cin_hi = '0;
      acc = col[HALF-1];
      for (int t = HALF - 2; t >= 0; t--) begin
         cin_lo[WIDTH-1-t] = acc & col[t];
         acc = acc | col[t];
      end
      tail_lo = acc;
      acc = col[WIDTH-1];
      for (int t = WIDTH - 2; t >= HALF; t--) begin
         cin_hi[WIDTH-1-t] = acc & col[t];
         acc = acc | col[t];
      end
      tail_hi = acc;
   end

   always_comb begin
      assert_bias_lo_count_R3 : assert ($countones(col[HALF-1:0]) ==
                                        $countones(cin_lo) + int'(tail_lo))
         else $error("lower bias count mismatch");
      assert_bias_hi_count_R3 : assert ($countones(col[WIDTH-1:HALF]) ==
                                        $countones(cin_hi) + int'(tail_hi))
         else $error("upper bias count mismatch");
   end
endmodule

// File: rtl/tcm_subarray.sv
module tcm_subarray #(
   parameter int WIDTH  = 8,
   parameter int ROW_LO = 0,
   parameter int ROW_HI = 3
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] cin_ext,
   output logic [WIDTH-1:0] sum_vec,
   output logic [WIDTH-1:0] car_vec
);
   logic [WIDTH-1:0] so_r [ROW_LO:ROW_HI];
   logic [WIDTH-1:0] co_r [ROW_LO:ROW_HI];

   for (genvar j = ROW_LO; j <= ROW_HI; j++) begin : g_row
      for (genvar i = 0; i < WIDTH; i++) begin : g_grp
         if (i + j >= WIDTH) begin : g_cell
            localparam int TOP = tcm_pkg::first_row(i, ROW_LO, WIDTH);
            logic s_in;
            logic c_in;
            if (j > ROW_LO && i < WIDTH - 1) begin : g_sdiag
               assign s_in = so_r[j-1][i+1];
            end else begin : g_sedge
               assign s_in = 1'b0;
            end
            if (j > TOP) begin : g_cchain
               assign c_in = co_r[j-1][i];
            end else begin : g_cinj
               assign c_in = cin_ext[i];
            end
            tcm_bypass_cell u_cell (
               .en      (a[i]),
               .mb      (b[j]),
               .sum_in  (s_in),
               .car_in  (c_in),
               .sum_out (so_r[j][i]),
               .car_out (co_r[j][i])
            );
         end else begin : g_void
            assign so_r[j][i] = 1'b0;
            assign co_r[j][i] = 1'b0;
         end
      end
   end

   always_comb begin
      sum_vec = '0;
      car_vec = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (i + ROW_HI >= WIDTH) begin
            sum_vec[i+ROW_HI-WIDTH]   = so_r[ROW_HI][i];
            car_vec[i+ROW_HI-WIDTH+1] = co_r[ROW_HI][i] & a[i];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         if (!a[i] && (i + ROW_HI >= WIDTH)) begin
            assert_bypass_carry_R5 : assert (co_r[ROW_HI][i] == 1'b0)
               else $error("bypassed group %0d leaks a carry", i);
         end
      end
   end
endmodule

// File: rtl/tcm_merge.sv
module tcm_merge #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] s_hi,
   input  logic [WIDTH-1:0] c_hi,
   input  logic [WIDTH-1:0] s_lo,
   input  logic [WIDTH-1:0] c_lo,
   input  logic             inj_hi,
   input  logic             inj_lo,
   output logic [WIDTH-1:0] prod
);
   logic [WIDTH-1:0] x1, m1, y1, x2, m2, y2;
   logic [WIDTH:0]   rc;

   assign x1 = s_hi ^ c_hi ^ s_lo;
   assign m1 = (s_hi & c_hi) | (s_hi & s_lo) | (c_hi & s_lo);
   assign y1 = {m1[WIDTH-2:0], inj_hi};
   assign x2 = x1 ^ y1 ^ c_lo;
   assign m2 = (x1 & y1) | (x1 & c_lo) | (y1 & c_lo);
   assign y2 = {m2[WIDTH-2:0], inj_lo};

   assign rc[0] = 1'b0;
   for (genvar k = 0; k < WIDTH; k++) begin : g_rip
      if (k == 0) begin : g_ha
         assign prod[k]  = x2[k] ^ y2[k];
         assign rc[k+1]  = x2[k] & y2[k];
      end else begin : g_fa
         assign prod[k]  = x2[k] ^ y2[k] ^ rc[k];
         assign rc[k+1]  = (x2[k] & y2[k]) | (x2[k] & rc[k]) | (y2[k] & rc[k]);
      end
   end

   always_comb begin
      logic [WIDTH-1:0] total;
      total = s_hi + c_hi + s_lo + c_lo + WIDTH'(inj_hi) + WIDTH'(inj_lo);
      assert_merge_sum_R8 : assert (prod == total)
         else $error("merge result %0h differs from operand sum %0h", prod, total);
   end
endmodule

// File: rtl/trunc_colbypass_mult.sv
module trunc_colbypass_mult #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] mcand,
   input  logic [WIDTH-1:0] mplier,
   output logic [WIDTH-1:0] prod
);
   localparam int HALF = WIDTH / 2;

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("WIDTH must be even and at least 4 (R9)");
   end

   logic [WIDTH-1:0] cin_lo, cin_hi;
   logic             tail_lo, tail_hi;
   logic [WIDTH-1:0] s_lo, c_lo, s_hi, c_hi;

   tcm_bias_net #(.WIDTH(WIDTH)) u_bias (
      .a       (mcand),
      .b       (mplier),
      .cin_lo  (cin_lo),
      .cin_hi  (cin_hi),
      .tail_lo (tail_lo),
      .tail_hi (tail_hi)
   );

   tcm_subarray #(.WIDTH(WIDTH), .ROW_LO(0), .ROW_HI(HALF-1)) u_lower (
      .a       (mcand),
      .b       (mplier),
      .cin_ext (cin_lo),
      .sum_vec (s_lo),
      .car_vec (c_lo)
   );

   tcm_subarray #(.WIDTH(WIDTH), .ROW_LO(HALF), .ROW_HI(WIDTH-1)) u_upper (
      .a       (mcand),
      .b       (mplier),
      .cin_ext (cin_hi),
      .sum_vec (s_hi),
      .car_vec (c_hi)
   );

   tcm_merge #(.WIDTH(WIDTH)) u_merge (
      .s_hi   (s_hi),
      .c_hi   (c_hi),
      .s_lo   (s_lo),
      .c_lo   (c_lo),
      .inj_hi (tail_hi),
      .inj_lo (tail_lo),
      .prod   (prod)
   );

   always_comb begin
      assert_bias_gated_R4 : assert (((cin_lo | cin_hi) & ~mcand) == '0)
         else $error("compensation carry into a disabled group");
      if (mcand == '0 || mplier == '0) begin
         assert_zero_operand_R6 : assert (prod == '0)
            else $error("nonzero product %0h with a zero operand", prod);
      end
   end
endmodule

// File: tb/test_trunc_colbypass_mult.sv
`timescale 1ns/1ps
module test_trunc_colbypass_mult;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [7:0]  a8 = '0, b8 = '0;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic [7:0]  p8;
   logic [3:0]  p4;
   logic [15:0] p16;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   trunc_colbypass_mult #(.WIDTH(8)) i_trunc_colbypass_mult (
      .mcand(a8), .mplier(b8), .prod(p8));
   trunc_colbypass_mult #(.WIDTH(4)) i_trunc_colbypass_mult_w4 (
      .mcand(a4), .mplier(b4), .prod(p4));
   trunc_colbypass_mult #(.WIDTH(16)) i_trunc_colbypass_mult_w16 (
      .mcand(a16), .mplier(b16), .prod(p16));

   // arithmetic model: kept terms plus one unit per set term of the top dropped column
   function automatic longint unsigned model(input int n, input longint unsigned a,
                                             input longint unsigned b);
      longint unsigned acc = 0;
      longint unsigned cnt = 0;
      for (int i = 0; i < n; i++) begin
         for (int j = 0; j < n; j++) begin
            if (a[i] && b[j]) begin
               if (i + j >= n)          acc += longint'(1) << (i + j - n);
               else if (i + j == n - 1) cnt += 1;
            end
         end
      end
      return (acc + cnt) & ((longint'(1) << n) - 1);
   endfunction

   task automatic chk(input string tag, input longint unsigned got,
                      input longint unsigned exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic put8(input logic [7:0] a, input logic [7:0] b);
      @(posedge clk);
      a8 = a; b8 = b;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // idle state with zero operands, R6
      @(negedge clk);
      chk("R6 idle", p8, 0);
      chk("R6 idle w4", p4, 0);
      chk("R6 idle w16", p16, 0);

      // R2: terms below the top dropped column vanish
      put8(8'h01, 8'h01); chk("R2 weight0", p8, 0);
      put8(8'h08, 8'h08); chk("R2 weight6", p8, 0);
      put8(8'h40, 8'h01); chk("R2 weight6b", p8, 0);
      // R3: single term on the top dropped column, every position
      for (int i = 0; i < 8; i++) begin
         put8(8'(1 << i), 8'(1 << (7 - i)));
         chk("R3 single", p8, 1);
      end
      // R3/R4: one lower-half and one upper-half term together
      put8(8'h81, 8'h81); chk("R3 both halves", p8, model(8, 8'h81, 8'h81));
      // kept single term at weight 8
      put8(8'h10, 8'h10); chk("R1 weight8", p8, 1);
      // R6: zero operands
      put8(8'h00, 8'hFF); chk("R6 a zero", p8, 0);
      put8(8'hFF, 8'h00); chk("R6 b zero", p8, 0);
      // R7: all ones
      put8(8'hFF, 8'hFF); chk("R7 all ones", p8, 255);
      // R5/R4: multiplicand with alternating zero groups
      put8(8'hAA, 8'hFF); chk("R5 alt groups", p8, model(8, 8'hAA, 8'hFF));
      put8(8'h0F, 8'hF0); chk("R4 low groups", p8, model(8, 8'h0F, 8'hF0));

      // full width-8 sweep (R1, R8), full width-4 sweep from low nibbles (R9),
      // sparse-multiplicand width-16 stream (R5)
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            @(posedge clk);
            a8  = 8'(x);
            b8  = 8'(y);
            a4  = 4'(x);
            b4  = 4'(y);
            a16 = 16'($urandom & $urandom & $urandom);
            b16 = 16'($urandom);
            if (x == 255 && y == 255) begin
               a16 = 16'hFFFF;
               b16 = 16'hFFFF;
            end
            @(negedge clk);
            chk("R1 R8 sweep w8", p8, model(8, a8, b8));
            chk("R9 sweep w4", p4, model(4, a4, b4));
            chk("R5 sparse w16", p16, model(16, a16, b16));
         end
      end
      chk("R7 all ones w16", p16, model(16, 16'hFFFF, 16'hFFFF));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule